// File: doc/BRIEF.md
# Fronthaul Link Delay Calculator

This block computes the timing figures that a baseband unit needs to drive one fronthaul port toward a radio. Each request carries the round-trip time measured on the link, the radio's frame-header turnaround, the requested channel bandwidth, and two stored radio delay profiles. Each profile holds a downlink processing delay and an uplink processing delay. The block picks one profile by bandwidth. From that profile it derives the one-way link delays in each direction, the transmit advance relative to the timing pulse, and the receive-position delay.

All quantities are unsigned nanosecond integers. The request interface is a valid/ready pair, and the block never applies backpressure. Results are registered and appear one clock after a request is accepted, together with a one-cycle done pulse. An error flag rejects any request whose arithmetic would fall outside the representable range. A rejected request leaves the previous results in place.

Top module: `fh_delay_calc`

## Requirements
- R1: During and after reset, and before any request, all four delay outputs are 0, `done_o` is 0 and `err_o` is 0. `in_ready_o` is 1 once reset has been released.
- R2: A `bw_khz_i` of exactly 3000 selects profile A (`pa_dl_i`, `pa_ul_i`). Every other bandwidth value selects profile B (`pb_dl_i`, `pb_ul_i`).
- R3: On a good request, `up_link_o` and `dn_link_o` both equal floor((`rtt_i` − `turn_i`) / 2).
- R4: On a good request, `tx_adv_o` equals the downlink link delay plus the selected profile's downlink processing delay.
- R5: On a good request, `rx_dly_o` equals the selected downlink delay plus the selected uplink delay minus `turn_i`.
- R6: When `rtt_i` < `turn_i`, the request raises `err_o` and all four delay outputs keep their previous values.
- R7: When the selected downlink delay plus uplink delay is less than `turn_i`, the request raises `err_o` and the outputs are held.
- R8: When the transmit advance or the receive delay would exceed 2^W − 1, the request raises `err_o` and the outputs are held.
- R9: `done_o` is high for exactly the one cycle after each accepted request. New results appear in that same cycle. With no request, `done_o` stays 0 and the outputs do not change.
- R10: `err_o` reflects only the most recent request, so a good request clears a previous error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request ready (always accepting once out of reset) |
| rtt_i | input | W | Measured link round-trip time, ns |
| turn_i | input | W | Radio frame-header turnaround, ns |
| bw_khz_i | input | W | Requested channel bandwidth, kHz |
| pa_dl_i | input | W | Profile A downlink processing delay, ns |
| pa_ul_i | input | W | Profile A uplink processing delay, ns |
| pb_dl_i | input | W | Profile B downlink processing delay, ns |
| pb_ul_i | input | W | Profile B uplink processing delay, ns |
| dn_link_o | output | W | One-way link delay toward the radio, ns |
| up_link_o | output | W | One-way link delay from the radio, ns |
| tx_adv_o | output | W | Transmit advance, ns |
| rx_dly_o | output | W | Receive delay, ns |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Last request was rejected |

## Verification
Every result, the done pulse and the error flag are due exactly one clock after the edge that accepts a request, with no other latency in the path. The bench drives each request on a falling edge and samples on the next falling edge, which falls half a period after the result edge. It then drops valid and, on some requests, samples one more idle falling edge to confirm that done has cleared and that the outputs are unchanged. Expected values come from integer arithmetic in the bench, and the bench tracks the last good results so that held outputs can be checked.

// File: rtl/fh_delay_pkg.sv
package fh_delay_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SHORT = 2'd1,
        FLT_NEGRX = 2'd2,
        FLT_RANGE = 2'd3
    } fault_e;

endpackage

// File: rtl/fh_profile_sel.sv
module fh_profile_sel #(
    parameter int W       = 24,
    parameter int SEL_KHZ = 3000
) (
    input  logic [W-1:0] bw_khz_i,
    input  logic [W-1:0] pa_dl_i,
    input  logic [W-1:0] pa_ul_i,
    input  logic [W-1:0] pb_dl_i,
    input  logic [W-1:0] pb_ul_i,
    output logic [W-1:0] dl_o,
    output logic [W-1:0] ul_o
);
    localparam logic [W-1:0] SEL_VAL = W'(SEL_KHZ);

    logic use_a;

    always_comb begin
        use_a = (bw_khz_i == SEL_VAL);
        dl_o  = use_a ? pa_dl_i : pb_dl_i;
        ul_o  = use_a ? pa_ul_i : pb_ul_i;
    end
endmodule

// File: rtl/fh_delay_math.sv
module fh_delay_math
    import fh_delay_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] rtt_i,
    input  logic [W-1:0] turn_i,
    input  logic [W-1:0] dl_i,
    input  logic [W-1:0] ul_i,
    output logic [W-1:0] link_o,
    output logic [W-1:0] tx_o,
    output logic [W-1:0] rx_o,
    output fault_e       fault_o
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] diff_s;
    logic signed [XW-1:0] half_s;
    logic signed [XW-1:0] tx_s;
    logic signed [XW-1:0] rx_s;

    always_comb begin
        diff_s = $signed({2'b00, rtt_i}) - $signed({2'b00, turn_i});
        half_s = diff_s >>> 1;
        tx_s   = half_s + $signed({2'b00, dl_i});
        rx_s   = $signed({2'b00, dl_i}) + $signed({2'b00, ul_i})
               - $signed({2'b00, turn_i});
        link_o = half_s[W-1:0];
        tx_o   = tx_s[W-1:0];
        rx_o   = rx_s[W-1:0];
        if (diff_s[XW-1])
            fault_o = FLT_SHORT;
        else if (rx_s[XW-1])
            fault_o = FLT_NEGRX;
        else if ((tx_s[XW-1:W] != 2'b00) || (rx_s[XW-1:W] != 2'b00))
            fault_o = FLT_RANGE;
        else
            fault_o = FLT_NONE;
    end
endmodule

// File: rtl/fh_delay_calc.sv
module fh_delay_calc
    import fh_delay_pkg::*;
#(
    parameter int W       = 24,
    parameter int SEL_KHZ = 3000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid_i,
    output logic         in_ready_o,
    input  logic [W-1:0] rtt_i,
    input  logic [W-1:0] turn_i,
    input  logic [W-1:0] bw_khz_i,
    input  logic [W-1:0] pa_dl_i,
    input  logic [W-1:0] pa_ul_i,
    input  logic [W-1:0] pb_dl_i,
    input  logic [W-1:0] pb_ul_i,
    output logic [W-1:0] dn_link_o,
    output logic [W-1:0] up_link_o,
    output logic [W-1:0] tx_adv_o,
    output logic [W-1:0] rx_dly_o,
    output logic         done_o,
    output logic         err_o
);
    typedef struct packed {
        logic [W-1:0] dn;
        logic [W-1:0] up;
        logic [W-1:0] tx;
        logic [W-1:0] rx;
        logic         done;
        logic         err;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] sel_dl, sel_ul;
    logic [W-1:0] link_v, tx_v, rx_v;
    fault_e       fault_v;
    logic         accept;

    fh_profile_sel #(.W(W), .SEL_KHZ(SEL_KHZ)) u_sel (
        .bw_khz_i (bw_khz_i),
        .pa_dl_i  (pa_dl_i),
        .pa_ul_i  (pa_ul_i),
        .pb_dl_i  (pb_dl_i),
        .pb_ul_i  (pb_ul_i),
        .dl_o     (sel_dl),
        .ul_o     (sel_ul)
    );

    fh_delay_math #(.W(W)) u_math (
        .rtt_i   (rtt_i),
        .turn_i  (turn_i),
        .dl_i    (sel_dl),
        .ul_i    (sel_ul),
        .link_o  (link_v),
        .tx_o    (tx_v),
        .rx_o    (rx_v),
        .fault_o (fault_v)
    );

    assign in_ready_o = 1'b1;
    assign accept     = in_valid_i & in_ready_o;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.done = 1'b1;
            st_d.err  = (fault_v != FLT_NONE);
            if (fault_v == FLT_NONE) begin
                st_d.dn = link_v;
                st_d.up = link_v;
                st_d.tx = tx_v;
                st_d.rx = rx_v;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dn_link_o = st_q.dn;
    assign up_link_o = st_q.up;
    assign tx_adv_o  = st_q.tx;
    assign rx_dly_o  = st_q.rx;
    assign done_o    = st_q.done;
    assign err_o     = st_q.err;

    // R9
    done_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> done_o);

    // R9
    done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(in_valid_i));

    // R6
    err_holds_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> ($stable(dn_link_o) && $stable(up_link_o)
                               && $stable(tx_adv_o) && $stable(rx_dly_o)));

    // R3
    link_halves_rtt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (({1'b0, dn_link_o, 1'b0} + {2'b00, $past(turn_i)}
                                  == {2'b00, $past(rtt_i)}) ||
                                 ({1'b0, dn_link_o, 1'b1} + {2'b00, $past(turn_i)}
                                  == {2'b00, $past(rtt_i)})));

    // R5
    rx_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ({2'b00, rx_dly_o} + {2'b00, $past(turn_i)}
                                 == {2'b00, $past(sel_dl)} + {2'b00, $past(sel_ul)}));

    // R4
    tx_ge_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (tx_adv_o >= dn_link_o));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(tx_adv_o) && $stable(rx_dly_o)));
endmodule

// File: tb/sim_fh_delay_calc.sv
module sim_fh_delay_calc;
    localparam int W = 24;
    localparam longint MAXV = (64'd1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] rtt = '0, turn = '0, bw = '0;
    logic [W-1:0] pa_dl = '0, pa_ul = '0, pb_dl = '0, pb_ul = '0;
    logic [W-1:0] dn_link, up_link, tx_adv, rx_dly;
    logic         done, err;

    int n_run = 0;
    int n_fail = 0;
    longint e_link = 0, e_tx = 0, e_rx = 0;
    bit     e_err = 0;

    always #10 clk = ~clk;

    fh_delay_calc #(.W(W), .SEL_KHZ(3000)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .rtt_i(rtt), .turn_i(turn), .bw_khz_i(bw),
        .pa_dl_i(pa_dl), .pa_ul_i(pa_ul), .pb_dl_i(pb_dl), .pb_ul_i(pb_ul),
        .dn_link_o(dn_link), .up_link_o(up_link), .tx_adv_o(tx_adv),
        .rx_dly_o(rx_dly), .done_o(done), .err_o(err)
    );

    task automatic check(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        check({req, " dn_link"}, dn_link, e_link);
        check({req, " up_link"}, up_link, e_link);
        check({req, " tx_adv"}, tx_adv, e_tx);
        check({req, " rx_dly"}, rx_dly, e_rx);
        check({req, " err"}, err, e_err);
    endtask

    task automatic request(longint r, longint t, longint b,
                           longint adl, longint aul, longint bdl, longint bul,
                           bit idle_chk);
        longint dl, ul, d, h, tx, rx;
        string  tag;
        rtt = W'(r); turn = W'(t); bw = W'(b);
        pa_dl = W'(adl); pa_ul = W'(aul); pb_dl = W'(bdl); pb_ul = W'(bul);
        in_valid = 1'b1;
        // R2: exactly 3000 kHz picks profile A
        dl = (b == 3000) ? adl : bdl;
        ul = (b == 3000) ? aul : bul;
        d  = r - t;
        h  = d / 2;
        tx = h + dl;
        rx = dl + ul - t;
        if (d < 0) begin
            tag = "R6"; e_err = 1;
        end else if (rx < 0) begin
            tag = "R7"; e_err = 1;
        end else if (tx > MAXV || rx > MAXV) begin
            tag = "R8"; e_err = 1;
        end else begin
            tag = (b == 3000) ? "R2/R3/R4/R5 profA" : "R2/R3/R4/R5 profB";
            e_err = 0; e_link = h; e_tx = tx; e_rx = rx;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 done", done, 1);
        // R10: err tracks this request only
        check_outs({tag, " R10"});
        if (idle_chk) begin
            @(negedge clk);
            check("R9 idle done", done, 0);
            check_outs("R9 idle hold");
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        longint rtts[8]  = '{0, 1, 625, 626, 627, 1652, 100001, 16777215};
        longint turns[4] = '{0, 626, 1651, 16777215};
        longint bws[6]   = '{3000, 5000, 0, 2999, 3001, 20000};
        longint prof[3][4] = '{'{23074, 20853, 14745, 11384},
                               '{100, 50, 10, 5},
                               '{16777000, 16777000, 16000000, 700000}};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 dn_link", dn_link, 0);
        check("R1 tx_adv", tx_adv, 0);
        check("R1 rx_dly", rx_dly, 0);
        check("R1 done", done, 0);
        check("R1 err", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", in_ready, 1);
        check("R1 done after release", done, 0);
        check("R1 up_link", up_link, 0);

        // worked example: 1652 ns round trip, 626 ns turnaround, 5 MHz profile
        request(1652, 626, 5000, 23074, 20853, 14745, 11384, 1);
        check("R3 example", dn_link, 513);
        check("R4 example", tx_adv, 15258);
        check("R5 example", rx_dly, 25503);

        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 4; j++)
                    for (int k = 0; k < 6; k++)
                        request(rtts[i], turns[j], bws[k],
                                prof[p][0], prof[p][1], prof[p][2], prof[p][3],
                                ((i + j + k) % 3) == 0);

        // R6 then R10: error, then a good request clears it
        request(10, 626, 5000, 23074, 20853, 14745, 11384, 1);
        request(2000, 626, 3000, 23074, 20853, 14745, 11384, 1);
        check("R10 cleared", err, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule